// File: doc/BRIEF.md
# Halfword-Aligned Instruction Fetch Aligner

This block sits between a 32-bit, word-organised instruction memory and an instruction decoder. A consumer hands it a program counter that needs only 2-byte alignment. The block reads the memory word that holds that address and picks out the halfword the PC points at. From the two low bits of that halfword it decides whether the instruction is a 16-bit compressed one or a full 32-bit one. A full instruction that starts in the upper half of a word spills into the next word. In that case the block issues a second read and joins the two halves.

The result goes out as a 32-bit instruction word plus a compressed flag. The consumer advances its PC by 2 when the flag is set and by 4 otherwise. A PC with bit 0 set is not fetched at all: it returns a misaligned flag instead. The request side and the result side each use a valid/ready handshake, and the block works on one request at a time.

Control is a four-state machine:
- **IDLE** waits for a request. A request with an odd PC goes straight to **HOLD** with the misaligned flag set. Any other request issues the first read and moves to **FIRST**.
- In **FIRST** the read data is present, and the block looks at the selected halfword.
  - If it holds a full instruction and the PC sits on the upper half of the word, the block issues the second read and moves to **SECOND**.
  - Otherwise it registers the result and moves to **HOLD**.
- **SECOND** joins the saved low half with the new word's lower half and moves to **HOLD**.
- **HOLD** presents the result until the consumer accepts it, then returns to **IDLE**.

The memory is little-endian. Its read data appears on the cycle after the read enable.

Top module: `ifetch_align`

## Requirements
- R1: After reset `out_valid` and `mem_rd_en` are 0 and `req_ready` is 1.
- R2: A selected halfword whose bits 1:0 equal 2'b11 starts a 32-bit instruction (`out_compressed`=0). Any other value in those bits gives a 16-bit instruction (`out_compressed`=1), returned in `out_instr[15:0]` with bits 31:16 zero.
- R3: For a PC with bits 1:0 = 2'b00 that points at a 32-bit instruction, exactly one read is made and `out_instr` equals the whole memory word.
- R4: A PC with bit 1 set selects bits 31:16 of the word. A PC with bit 1 clear selects bits 15:0. A compressed instruction always takes exactly one read.
- R5: A PC with bits 1:0 = 2'b10 whose selected halfword ends in 2'b11 takes two reads, the second at the next word address. Then `out_instr[15:0]` is the first word's bits 31:16 and `out_instr[31:16]` is the second word's bits 15:0. No further read follows the second one.
- R6: Every `mem_addr` driven with `mem_rd_en` has bits 1:0 = 0. The first read of a request is at the PC with bits 1:0 cleared.
- R7: A PC with bit 0 set makes no memory read. It returns `out_misaligned`=1, `out_compressed`=0 and `out_instr`=0.
- R8: While `out_valid`=1 and `out_ready`=0 the outputs hold stable. While a result is held no read is made and `req_ready` is 0.
- R9: `out_valid` rises 1 cycle after acceptance for a misaligned PC, 2 cycles after for a one-read fetch, and 3 cycles after for a two-read fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Fetch request present |
| req_ready | output | 1 | Block can accept a request (IDLE) |
| req_pc | input | PC_W | Byte address of the instruction |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_addr | output | PC_W | Word-aligned byte address of the read |
| mem_rd_data | input | 32 | Read data, valid the cycle after `mem_rd_en` |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer accepts the result |
| out_instr | output | 32 | Assembled instruction |
| out_compressed | output | 1 | 1: 16-bit instruction, advance PC by 2 |
| out_misaligned | output | 1 | 1: PC bit 0 was set, nothing fetched |

## Verification
Each fault in the state machine shows at the ports within one request.
- A wrong branch out of FIRST shows as a third read, a missing second read, or a wrong upper half in the joined instruction. The port values are compared against memory contents known to the bench.
- Landing in HOLD a cycle early or late changes the cycle on which `out_valid` rises.
- A stale low-half register or a wrong halfword select corrupts `out_instr` on that same result.
- Leaving HOLD without an acceptance drops a result from the expected queue, or lets a new request in while the old one is pending.

// File: rtl/ifa_pkg.sv
package ifa_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FIRST  = 2'd1,
        ST_SECOND = 2'd2,
        ST_HOLD   = 2'd3
    } ifa_state_e;

    localparam int ILEN = 32;
    localparam int HLEN = ILEN / 2;
endpackage

// File: rtl/ifa_half_sel.sv
module ifa_half_sel #(
    parameter int HW = 16
) (
    input  logic [2*HW-1:0] word,
    input  logic            upper,
    output logic [HW-1:0]   half
);
    always_comb begin
        half = upper ? word[2*HW-1:HW] : word[HW-1:0];
    end
endmodule

// File: rtl/ifa_len_chk.sv
module ifa_len_chk (
    input  logic [1:0] low_bits,
    output logic       is_full
);
    always_comb begin
        is_full = (low_bits == 2'b11);
    end
endmodule

// File: rtl/ifa_stitch.sv
module ifa_stitch #(
    parameter int HW = 16
) (
    input  logic [HW-1:0]   lo,
    input  logic [HW-1:0]   hi,
    input  logic            full,
    output logic [2*HW-1:0] instr,
    output logic            compressed
);
    always_comb begin
        compressed = ~full;
        instr      = full ? {hi, lo} : {{HW{1'b0}}, lo};
    end
endmodule

// File: rtl/ifetch_align.sv
module ifetch_align
    import ifa_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [PC_W-1:0] req_pc,
    output logic            mem_rd_en,
    output logic [PC_W-1:0] mem_addr,
    input  logic [ILEN-1:0] mem_rd_data,
    output logic            out_valid,
    input  logic            out_ready,
    output logic [ILEN-1:0] out_instr,
    output logic            out_compressed,
    output logic            out_misaligned
);
    localparam int WBYTES = ILEN / 8;
    localparam int WOFS   = $clog2(WBYTES);
    localparam int WA_W   = PC_W - WOFS;

    ifa_state_e state_q, state_d;

    logic [PC_W-1:1] pc_q;
    logic [HLEN-1:0] lo_q;
    logic [ILEN-1:0] instr_q;
    logic            comp_q;
    logic            mis_q;

    logic [HLEN-1:0] cur_half;
    logic            cur_full;
    logic [HLEN-1:0] lo_src;
    logic [HLEN-1:0] hi_src;
    logic            join_full;
    logic [ILEN-1:0] joined;
    logic            joined_comp;
    logic            accept;
    logic            straddle;
    logic            load_out;
    logic [WA_W-1:0] next_word;

    ifa_half_sel #(.HW(HLEN)) u_sel (
        .word  (mem_rd_data),
        .upper (pc_q[1]),
        .half  (cur_half)
    );

    ifa_len_chk u_len (
        .low_bits (cur_half[1:0]),
        .is_full  (cur_full)
    );

    ifa_stitch #(.HW(HLEN)) u_join (
        .lo         (lo_src),
        .hi         (hi_src),
        .full       (join_full),
        .instr      (joined),
        .compressed (joined_comp)
    );

    always_comb begin
        lo_src    = (state_q == ST_SECOND) ? lo_q : cur_half;
        hi_src    = (state_q == ST_SECOND) ? mem_rd_data[HLEN-1:0]
                                           : mem_rd_data[ILEN-1:HLEN];
        join_full = (state_q == ST_SECOND) ? 1'b1 : cur_full;
        next_word = pc_q[PC_W-1:WOFS] + {{(WA_W-1){1'b0}}, 1'b1};
        accept    = (state_q == ST_IDLE) && req_valid;
        straddle  = (state_q == ST_FIRST) && cur_full && pc_q[1];
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state and memory strobes
    always_comb begin
        state_d   = state_q;
        mem_rd_en = 1'b0;
        mem_addr  = {req_pc[PC_W-1:WOFS], {WOFS{1'b0}}};
        load_out  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    if (req_pc[0]) begin
                        state_d  = ST_HOLD;
                        load_out = 1'b1;
                    end else begin
                        state_d   = ST_FIRST;
                        mem_rd_en = 1'b1;
                    end
                end
            end
            ST_FIRST: begin
                if (straddle) begin
                    state_d   = ST_SECOND;
                    mem_rd_en = 1'b1;
                    mem_addr  = {next_word, {WOFS{1'b0}}};
                end else begin
                    state_d  = ST_HOLD;
                    load_out = 1'b1;
                end
            end
            ST_SECOND: begin
                state_d  = ST_HOLD;
                load_out = 1'b1;
            end
            ST_HOLD: begin
                if (out_ready) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // data path registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q    <= '0;
            lo_q    <= '0;
            instr_q <= '0;
            comp_q  <= 1'b0;
            mis_q   <= 1'b0;
        end else begin
            if (accept) pc_q <= req_pc[PC_W-1:1];
            if (straddle) lo_q <= cur_half;
            if (load_out) begin
                if (accept) begin
                    instr_q <= '0;
                    comp_q  <= 1'b0;
                    mis_q   <= 1'b1;
                end else begin
                    instr_q <= joined;
                    comp_q  <= joined_comp;
                    mis_q   <= 1'b0;
                end
            end
        end
    end

    // outputs
    always_comb begin
        req_ready      = (state_q == ST_IDLE);
        out_valid      = (state_q == ST_HOLD);
        out_instr      = instr_q;
        out_compressed = comp_q;
        out_misaligned = mis_q;
    end
endmodule

// File: rtl/ifa_checker.sv
module ifa_checker #(
    parameter int PC_W = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            req_ready,
    input logic [PC_W-1:0] req_pc,
    input logic            mem_rd_en,
    input logic [PC_W-1:0] mem_addr,
    input logic            out_valid,
    input logic            out_ready,
    input logic [31:0]     out_instr,
    input logic            out_compressed,
    input logic            out_misaligned
);
    assert_word_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> (mem_addr[1:0] == 2'b00));

    assert_first_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !req_pc[0]) |->
            (mem_rd_en && mem_addr[PC_W-1:2] == req_pc[PC_W-1:2]));

    assert_no_read_odd_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_pc[0]) |-> !mem_rd_en);

    assert_mis_result_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_misaligned) |-> (out_instr == 32'd0 && !out_compressed));

    assert_len_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_misaligned) |->
            (out_compressed == (out_instr[1:0] != 2'b11)));

    assert_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_compressed) |-> (out_instr[31:16] == 16'd0));

    assert_hold_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=>
            (out_valid && $stable(out_instr) && $stable(out_compressed)
             && $stable(out_misaligned)));

    assert_quiet_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (!mem_rd_en && !req_ready));

    assert_two_reads_max_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_en && !req_ready) |=> !mem_rd_en);
endmodule

bind ifetch_align ifa_checker #(.PC_W(PC_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_ready      (req_ready),
    .req_pc         (req_pc),
    .mem_rd_en      (mem_rd_en),
    .mem_addr       (mem_addr),
    .out_valid      (out_valid),
    .out_ready      (out_ready),
    .out_instr      (out_instr),
    .out_compressed (out_compressed),
    .out_misaligned (out_misaligned)
);

// File: tb/tb_ifetch_align.sv
module tb_ifetch_align;
    localparam int PC_W = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0;
    logic            req_ready;
    logic [PC_W-1:0] req_pc = '0;
    logic            mem_rd_en;
    logic [PC_W-1:0] mem_addr;
    logic [31:0]     mem_rd_data = '0;
    logic            out_valid;
    logic            out_ready = 1'b1;
    logic [31:0]     out_instr;
    logic            out_compressed;
    logic            out_misaligned;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    ifetch_align #(.PC_W(PC_W)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_pc(req_pc), .mem_rd_en(mem_rd_en), .mem_addr(mem_addr),
        .mem_rd_data(mem_rd_data), .out_valid(out_valid), .out_ready(out_ready),
        .out_instr(out_instr), .out_compressed(out_compressed),
        .out_misaligned(out_misaligned)
    );

    // memory model: 16 words, wraps on the address, data one cycle later
    logic [31:0] mem [16];
    int          rd_cnt = 0;
    logic [31:0] first_addr = '0;

    always @(posedge clk) begin
        if (mem_rd_en) begin
            mem_rd_data <= mem[mem_addr[5:2]];
            if (rd_cnt == 0) first_addr <= mem_addr;
            rd_cnt <= rd_cnt + 1;
        end
    end

    function automatic logic [15:0] half_at(input logic [31:0] a);
        logic [31:0] w;
        w = mem[a[5:2]];
        return a[1] ? w[31:16] : w[15:0];
    endfunction

    // scoreboard queue: {misaligned, compressed, instr}
    logic [33:0] exp_q [$];
    string       tag_q [$];

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [33:0] act, input logic [33:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic do_fetch(input logic [31:0] pc, input string tag);
        logic [15:0] lo;
        logic [15:0] hi;
        logic [33:0] e;
        int          exp_reads;
        int          exp_lat;
        int          lat;
        if (pc[0]) begin
            e = {1'b1, 1'b0, 32'd0};
            exp_reads = 0;
            exp_lat = 1;
        end else begin
            lo = half_at(pc);
            if (lo[1:0] != 2'b11) begin
                e = {1'b0, 1'b1, 16'd0, lo};
                exp_reads = 1;
                exp_lat = 2;
            end else begin
                hi = half_at(pc + 32'd2);
                e = {1'b0, 1'b0, hi, lo};
                exp_reads = pc[1] ? 2 : 1;
                exp_lat = pc[1] ? 3 : 2;
            end
        end
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        rd_cnt = 0;
        req_pc = pc;
        req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (!out_valid && lat < 10) begin
            @(negedge clk);
            lat++;
        end
        check(lat == exp_lat, "R9", "latency", 34'(lat), 34'(exp_lat));
        check(rd_cnt == exp_reads, tag, "read count", 34'(rd_cnt), 34'(exp_reads));
        if (exp_reads > 0)
            check(first_addr == {pc[31:2], 2'b00}, "R6", "first address",
                  34'(first_addr), 34'({pc[31:2], 2'b00}));
        while (!req_ready) @(negedge clk);
    endtask

    // monitor: compare accepted results, and hold stability (R8)
    bit          held = 0;
    logic [33:0] held_val = '0;
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (held) begin
                check(out_valid && {out_misaligned, out_compressed, out_instr} == held_val,
                      "R8", "stall stability",
                      {out_misaligned, out_compressed, out_instr}, held_val);
            end
            held = out_valid && !out_ready;
            held_val = {out_misaligned, out_compressed, out_instr};
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R8", "unexpected result",
                          {out_misaligned, out_compressed, out_instr}, 34'd0);
                end else begin
                    logic [33:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check({out_misaligned, out_compressed, out_instr} == e, t, "result",
                          {out_misaligned, out_compressed, out_instr}, e);
                end
            end
        end
    end

    // consumer back-pressure pattern
    initial begin
        int tick = 0;
        forever begin
            @(negedge clk);
            tick++;
            out_ready = ((tick % 7) != 3) && ((tick % 7) != 4);
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) mem[i] = 32'h0000_0001 + 32'(i) * 32'h0004_0000;
        mem[0]  = 32'h00B3_0513;
        mem[1]  = 32'h1F03_4501;
        mem[2]  = 32'h8082_ABCD;
        mem[3]  = 32'h4285_0613;
        mem[4]  = 32'h5A5B_C3C3;
        mem[5]  = 32'h0007_9E02;
        mem[15] = 32'h1233_6E10;

        repeat (3) @(negedge clk);
        check(req_ready == 1'b1, "R1", "req_ready after reset", 34'(req_ready), 34'd1);
        check(out_valid == 1'b0, "R1", "out_valid after reset", 34'(out_valid), 34'd0);
        check(mem_rd_en == 1'b0, "R1", "mem_rd_en after reset", 34'(mem_rd_en), 34'd0);
        rst_n = 1'b1;

        do_fetch(32'h0000_0000, "R3");  // aligned 32-bit word
        do_fetch(32'h0000_0004, "R4");  // compressed, lower half
        do_fetch(32'h0000_0006, "R5");  // straddles words 1 and 2
        do_fetch(32'h0000_0008, "R2");  // compressed, lower half
        do_fetch(32'h0000_000A, "R4");  // compressed, upper half
        do_fetch(32'h0000_000C, "R3");  // aligned 32-bit
        do_fetch(32'h0000_000E, "R4");  // compressed, upper half
        do_fetch(32'h0000_0005, "R7");  // odd PC
        do_fetch(32'h0000_0012, "R5");  // straddles words 4 and 5
        do_fetch(32'h0000_0010, "R3");  // full word ending in 11
        do_fetch(32'h0000_003E, "R5");  // straddle into next block
        do_fetch(32'h0000_0017, "R7");  // odd PC
        do_fetch(32'h0000_0014, "R2");  // compressed, ends in 10
        for (int i = 0; i < 6; i++) do_fetch(32'(i * 6 + 2), "R2");

        repeat (10) @(negedge clk);
        check(exp_q.size() == 0, "R8", "all results delivered", 34'(exp_q.size()), 34'd0);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule